// File: doc/BRIEF.md
# First-Level Data Cache Intake Dispatcher

This block sits at the entry of a first-level data cache. It takes work from three input queues and places it into three tag-pipeline stages. The queues carry replies from the next cache level, processor requests and coherence messages. Each queue head is a valid/ready stream. An item moves when `valid` and `ready` are both high at a rising clock edge. A head that is refused stays where it is, so only that queue stalls. The other two queues keep moving. Items arrive in this order of service: replies, then requests, then coherence. Each queue feeds its own pipeline, so no queue takes capacity from another.

Processor requests go to one of three places. A request marked as system-control goes to a local control handler. An uncached request goes to an uncached-access buffer. Every other request enters the request tag pipeline. Both side paths are valid/ready streams that share the request payload. Each pipeline holds up to `NPORTS` items in holding registers, and each register is shown downstream as one output slot. The slots are presented in order, and presentation stops at the first empty slot. An item leaves only in a cycle where its slot is presented and its `done` bit is high. Otherwise it stays in place for a retry.

The block also tracks three more things. It counts the items held in the pipelines. It keeps a full flag for the request queue. It raises an "inputs empty" indication only after a cycle in which no queue was left blocked.

Top module: `l1d_intake`

## Requirements
- R1: `rep_ready` is high exactly when `pipe_accept[0]` is high and the reply pipeline holds fewer than `NPORTS` items. `coh_ready` follows the same rule with `pipe_accept[2]` and the coherence pipeline. The request tag path follows it with `pipe_accept[1]`. A slot freed in a cycle cannot accept a new item in that same cycle.
- R2: An item accepted at a clock edge is presented on its pipeline's slots from the following cycle. Items in one pipeline keep their arrival order across the slots.
- R3: Request routing has a fixed priority. `req_sysctl` wins over `req_uncached`, and `req_uncached` wins over the tag pipeline. Only the chosen destination sees `valid` (`sc_valid`, `ub_valid` or the tag pipeline). `req_ready` copies that destination's ready. `sc_data` and `ub_data` carry `req_data`.
- R4: After reset, `in_empty` is 1. After each clock edge, `in_empty` is 1 when, in the cycle before, no queue showed `valid` with `ready` low. Otherwise it is 0.
- R5: `inpipe_cnt` resets to 0. At each clock edge it rises by one for each item accepted into a pipeline and falls by one for each item retired. It never exceeds 3*`NPORTS`.
- R6: `req_full` resets to 0. It becomes 0 after an edge where a request entered the tag pipeline. It takes the value of `req_q_full` after an edge where a request left through the control or uncached path. Otherwise it holds its value.
- R7: `rel_strobe` is high in exactly those cycles where a request is being accepted into the tag pipeline and `req_prefetch` is low.
- R8: Slot i of a pipeline shows `valid` only when slots 0 through i all hold items. An item retires when its slot shows `valid` and its `slot_done` bit is high. An item that is not retired stays presented with unchanged data.
- R9: After retirements, the remaining items move toward slot 0 and keep their order. A new item is placed behind them. The slot arrays are laid out flat, with pipeline p (0 reply, 1 request, 2 coherence) and slot i at bit p*`NPORTS`+i. Data for that slot sits at bits (p*`NPORTS`+i)*`W` upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_valid | input | 1 | Reply queue head valid |
| rep_data | input | W | Reply payload |
| rep_ready | output | 1 | Reply head accepted |
| req_valid | input | 1 | Request queue head valid |
| req_data | input | W | Request payload |
| req_sysctl | input | 1 | Request is for the local control handler |
| req_uncached | input | 1 | Request has the uncached attribute |
| req_prefetch | input | 1 | Request is an internal prefetch |
| req_q_full | input | 1 | Request queue full level after a pop |
| req_ready | output | 1 | Request head accepted by its destination |
| coh_valid | input | 1 | Coherence queue head valid |
| coh_data | input | W | Coherence payload |
| coh_ready | output | 1 | Coherence head accepted |
| pipe_accept | input | 3 | Per-pipeline accept enable (stub) |
| sc_valid | output | 1 | Control handler request valid |
| sc_data | output | W | Control handler payload |
| sc_ready | input | 1 | Control handler ready |
| ub_valid | output | 1 | Uncached buffer request valid |
| ub_data | output | W | Uncached buffer payload |
| ub_ready | input | 1 | Uncached buffer ready |
| rel_strobe | output | 1 | Release a processor request slot |
| slot_valid | output | 3*NPORTS | Presented pipeline slots |
| slot_data | output | 3*NPORTS*W | Slot payloads |
| slot_done | input | 3*NPORTS | Downstream processed the slot |
| inpipe_cnt | output | clog2(3*NPORTS+1) | Items held in pipelines |
| req_full | output | 1 | Request queue full flag |
| in_empty | output | 1 | No queue was left blocked |

## Verification
The results fall into two timing groups. The first group is combinational: the ready, routing and strobe outputs follow the current cycle's inputs and stored state. The second group is registered: slot contents, `inpipe_cnt`, `req_full` and `in_empty` change one clock edge after the stimulus that causes them. The bench changes inputs on the falling edge and samples 1 ns later. At that point it compares the combinational outputs against a model computed from the requirements. It compares the registered outputs against the model state left by the previous edge. The model then advances one step per edge. The run switches between phases where retirement is frequent, rare, always or never, so every pipeline fills, blocks and drains.

// File: rtl/l1d_intake_pkg.sv
`timescale 1ns/1ps
package l1d_intake_pkg;
  localparam int NUM_PIPES = 3;
  localparam int IDX_REPLY = 0;
  localparam int IDX_REQ   = 1;
  localparam int IDX_COH   = 2;

  typedef enum logic [1:0] {
    ROUTE_TAG      = 2'd0,
    ROUTE_SYSCTL   = 2'd1,
    ROUTE_UNCACHED = 2'd2
  } req_route_e;
endpackage

// File: rtl/intake_pipe.sv
`timescale 1ns/1ps
module intake_pipe #(
  parameter int NPORTS = 1,
  parameter int W      = 32,
  localparam int CW    = $clog2(NPORTS + 1),
  localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_data,
  input  logic                 accept_en,
  output logic                 in_ready,
  output logic [NPORTS-1:0]    slot_valid,
  output logic [NPORTS*W-1:0]  slot_data,
  input  logic [NPORTS-1:0]    slot_done,
  output logic [CW-1:0]        retired
);
  logic [NPORTS-1:0] vld_q, vld_d;
  logic [W-1:0]      dat_q [NPORTS];
  logic [W-1:0]      dat_d [NPORTS];
  logic [NPORTS-1:0] pres;
  logic [NPORTS-1:0] ret;
  logic [CW-1:0]     occ;

  // presentation stops at the first empty holding register
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < NPORTS; i++) begin
      run     = run & vld_q[i];
      pres[i] = run;
    end
  end

  assign ret        = pres & slot_done;
  assign occ        = CW'($countones(vld_q));
  assign retired    = CW'($countones(ret));
  assign in_ready   = accept_en && (occ < CW'(NPORTS));
  assign slot_valid = pres;

  generate
    for (genvar g = 0; g < NPORTS; g++) begin : g_out
      assign slot_data[g*W +: W] = dat_q[g];
    end
  endgenerate

  // compact survivors toward slot 0, then append the new arrival
  always_comb begin
    int wp;
    wp    = 0;
    vld_d = '0;
    for (int i = 0; i < NPORTS; i++) dat_d[i] = dat_q[i];
    for (int i = 0; i < NPORTS; i++) begin
      if (vld_q[i] && !ret[i]) begin
        vld_d[wp[IW-1:0]] = 1'b1;
        dat_d[wp[IW-1:0]] = dat_q[i];
        wp++;
      end
    end
    if (in_valid && in_ready && (wp < NPORTS)) begin
      vld_d[wp[IW-1:0]] = 1'b1;
      dat_d[wp[IW-1:0]] = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NPORTS; i++) dat_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < NPORTS; i++) dat_q[i] <= dat_d[i];
    end
  end
endmodule

// File: rtl/req_steer.sv
`timescale 1ns/1ps
module req_steer
  import l1d_intake_pkg::*;
(
  input  logic req_valid,
  input  logic req_sysctl,
  input  logic req_uncached,
  input  logic req_prefetch,
  input  logic sc_ready,
  input  logic ub_ready,
  input  logic tag_ready,
  output logic sc_valid,
  output logic ub_valid,
  output logic tag_valid,
  output logic req_ready,
  output logic tag_take,
  output logic side_take,
  output logic release_ok
);
  req_route_e route;

  always_comb begin
    if (req_sysctl)        route = ROUTE_SYSCTL;
    else if (req_uncached) route = ROUTE_UNCACHED;
    else                   route = ROUTE_TAG;

    sc_valid  = req_valid && (route == ROUTE_SYSCTL);
    ub_valid  = req_valid && (route == ROUTE_UNCACHED);
    tag_valid = req_valid && (route == ROUTE_TAG);

    unique case (route)
      ROUTE_SYSCTL:   req_ready = sc_ready;
      ROUTE_UNCACHED: req_ready = ub_ready;
      default:        req_ready = tag_ready;
    endcase

    tag_take   = tag_valid && tag_ready;
    side_take  = (sc_valid && sc_ready) || (ub_valid && ub_ready);
    release_ok = tag_take && !req_prefetch;
  end
endmodule

// File: rtl/l1d_intake.sv
`timescale 1ns/1ps
module l1d_intake
  import l1d_intake_pkg::*;
#(
  parameter int NPORTS = 1,
  parameter int W      = 32,
  localparam int CNTW  = $clog2(NUM_PIPES*NPORTS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rep_valid,
  input  logic [W-1:0]                   rep_data,
  output logic                           rep_ready,
  input  logic                           req_valid,
  input  logic [W-1:0]                   req_data,
  input  logic                           req_sysctl,
  input  logic                           req_uncached,
  input  logic                           req_prefetch,
  input  logic                           req_q_full,
  output logic                           req_ready,
  input  logic                           coh_valid,
  input  logic [W-1:0]                   coh_data,
  output logic                           coh_ready,
  input  logic [NUM_PIPES-1:0]           pipe_accept,
  output logic                           sc_valid,
  output logic [W-1:0]                   sc_data,
  input  logic                           sc_ready,
  output logic                           ub_valid,
  output logic [W-1:0]                   ub_data,
  input  logic                           ub_ready,
  output logic                           rel_strobe,
  output logic [NUM_PIPES*NPORTS-1:0]    slot_valid,
  output logic [NUM_PIPES*NPORTS*W-1:0]  slot_data,
  input  logic [NUM_PIPES*NPORTS-1:0]    slot_done,
  output logic [CNTW-1:0]                inpipe_cnt,
  output logic                           req_full,
  output logic                           in_empty
);
  localparam int PCW = $clog2(NPORTS + 1);

  logic           pin_valid [NUM_PIPES];
  logic [W-1:0]   pin_data  [NUM_PIPES];
  logic           pin_ready [NUM_PIPES];
  logic [PCW-1:0] pret      [NUM_PIPES];

  logic tag_valid, tag_take, side_take, release_ok;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic full_q, empty_q, blocked;

  req_steer u_steer (
    .req_valid    (req_valid),
    .req_sysctl   (req_sysctl),
    .req_uncached (req_uncached),
    .req_prefetch (req_prefetch),
    .sc_ready     (sc_ready),
    .ub_ready     (ub_ready),
    .tag_ready    (pin_ready[IDX_REQ]),
    .sc_valid     (sc_valid),
    .ub_valid     (ub_valid),
    .tag_valid    (tag_valid),
    .req_ready    (req_ready),
    .tag_take     (tag_take),
    .side_take    (side_take),
    .release_ok   (release_ok)
  );

  assign sc_data    = req_data;
  assign ub_data    = req_data;
  assign rel_strobe = release_ok;

  assign pin_valid[IDX_REPLY] = rep_valid;
  assign pin_data [IDX_REPLY] = rep_data;
  assign pin_valid[IDX_REQ]   = tag_valid;
  assign pin_data [IDX_REQ]   = req_data;
  assign pin_valid[IDX_COH]   = coh_valid;
  assign pin_data [IDX_COH]   = coh_data;

  assign rep_ready = pin_ready[IDX_REPLY];
  assign coh_ready = pin_ready[IDX_COH];

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      intake_pipe #(.NPORTS(NPORTS), .W(W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (pin_valid[p]),
        .in_data    (pin_data[p]),
        .accept_en  (pipe_accept[p]),
        .in_ready   (pin_ready[p]),
        .slot_valid (slot_valid[p*NPORTS +: NPORTS]),
        .slot_data  (slot_data[p*NPORTS*W +: NPORTS*W]),
        .slot_done  (slot_done[p*NPORTS +: NPORTS]),
        .retired    (pret[p])
      );
    end
  endgenerate

  always_comb begin
    int s;
    s = int'(cnt_q);
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (pin_valid[p] && pin_ready[p]) s = s + 1;
      s = s - int'(pret[p]);
    end
    cnt_d = CNTW'(s);
  end

  assign blocked = (rep_valid && !rep_ready) ||
                   (req_valid && !req_ready) ||
                   (coh_valid && !coh_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      empty_q <= !blocked;
      if (tag_take)       full_q <= 1'b0;
      else if (side_take) full_q <= req_q_full;
    end
  end

  assign inpipe_cnt = cnt_q;
  assign req_full   = full_q;
  assign in_empty   = empty_q;
endmodule

// File: rtl/l1d_intake_chk.sv
`timescale 1ns/1ps
module l1d_intake_chk
  import l1d_intake_pkg::*;
#(
  parameter int NPORTS = 1,
  parameter int W      = 32,
  localparam int CNTW  = $clog2(NUM_PIPES*NPORTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_sysctl,
  input logic              req_uncached,
  input logic              req_prefetch,
  input logic              sc_valid,
  input logic              ub_valid,
  input logic              rel_strobe,
  input logic [NPORTS-1:0] rep_slots,
  input logic [W-1:0]      head_data,
  input logic              head_done,
  input logic [CNTW-1:0]   inpipe_cnt,
  input logic              req_full,
  input logic              in_empty
);
  a_r1_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (&rep_slots) |-> !rep_ready);

  a_r3_single_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sc_valid, ub_valid}));

  a_r3_sysctl_first: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> req_sysctl);

  a_r3_uncached_second: assert property (@(posedge clk) disable iff (!rst_n)
    ub_valid |-> (!req_sysctl && req_uncached));

  a_r4_block_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> !in_empty);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inpipe_cnt <= CNTW'(NUM_PIPES*NPORTS));

  a_r6_tag_entry_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sysctl && !req_uncached) |=> !req_full);

  a_r7_strobe_only_on_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rel_strobe |-> (req_valid && req_ready && !req_sysctl && !req_uncached && !req_prefetch));

  a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_slots[0] && !head_done) |=> (rep_slots[0] && $stable(head_data)));
endmodule

bind l1d_intake l1d_intake_chk #(.NPORTS(NPORTS), .W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rep_valid    (rep_valid),
  .rep_ready    (rep_ready),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_sysctl   (req_sysctl),
  .req_uncached (req_uncached),
  .req_prefetch (req_prefetch),
  .sc_valid     (sc_valid),
  .ub_valid     (ub_valid),
  .rel_strobe   (rel_strobe),
  .rep_slots    (slot_valid[NPORTS-1:0]),
  .head_data    (slot_data[W-1:0]),
  .head_done    (slot_done[0]),
  .inpipe_cnt   (inpipe_cnt),
  .req_full     (req_full),
  .in_empty     (in_empty)
);

// File: tb/l1d_intake_bench.sv
`timescale 1ns/1ps
module l1d_intake_bench;
  localparam int NP    = 2;
  localparam int W     = 8;
  localparam int NPIPE = 3;
  localparam int CNTW  = $clog2(NPIPE*NP + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic rep_valid, req_valid, coh_valid;
  logic [W-1:0] rep_data, req_data, coh_data;
  logic req_sysctl, req_uncached, req_prefetch, req_q_full;
  logic rep_ready, req_ready, coh_ready;
  logic [NPIPE-1:0] pipe_accept;
  logic sc_valid, sc_ready, ub_valid, ub_ready, rel_strobe;
  logic [W-1:0] sc_data, ub_data;
  logic [NPIPE*NP-1:0] slot_valid, slot_done;
  logic [NPIPE*NP*W-1:0] slot_data;
  logic [CNTW-1:0] inpipe_cnt;
  logic req_full, in_empty;

  always #4 clk = ~clk;

  l1d_intake #(.NPORTS(NP), .W(W)) u_l1d_intake (
    .clk(clk), .rst_n(rst_n),
    .rep_valid(rep_valid), .rep_data(rep_data), .rep_ready(rep_ready),
    .req_valid(req_valid), .req_data(req_data), .req_sysctl(req_sysctl),
    .req_uncached(req_uncached), .req_prefetch(req_prefetch),
    .req_q_full(req_q_full), .req_ready(req_ready),
    .coh_valid(coh_valid), .coh_data(coh_data), .coh_ready(coh_ready),
    .pipe_accept(pipe_accept),
    .sc_valid(sc_valid), .sc_data(sc_data), .sc_ready(sc_ready),
    .ub_valid(ub_valid), .ub_data(ub_data), .ub_ready(ub_ready),
    .rel_strobe(rel_strobe),
    .slot_valid(slot_valid), .slot_data(slot_data), .slot_done(slot_done),
    .inpipe_cnt(inpipe_cnt), .req_full(req_full), .in_empty(in_empty)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic         mv [NPIPE][NP];
  logic [W-1:0] md [NPIPE][NP];
  int           mcnt;
  logic         mempty, mfull;
  logic [31:0]  lf = 32'h1ACE_5EED;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic one_cycle(input int phase);
    logic [31:0] r1, r2;
    logic [NPIPE*NP-1:0] bias;
    logic pres [NPIPE][NP];
    int occ [NPIPE];
    logic erep, ecoh, etag, ereq, etake, inval, rdy, run, blocked;
    @(negedge clk);
    lf = step(lf); r1 = lf;
    lf = step(lf); r2 = lf;
    rep_valid    = r1[0];  rep_data = r1[15:8];
    req_valid    = r1[1];  req_data = r1[23:16];
    req_sysctl   = r1[2] & r1[3];
    req_uncached = r1[4] & r1[5];
    req_prefetch = r1[6];
    req_q_full   = r1[7];
    coh_valid    = r1[24]; coh_data = r2[31:24];
    pipe_accept  = r2[2:0] | r2[13:11];
    sc_ready     = r2[3];
    ub_ready     = r2[4];
    case (phase)
      0: bias = r2[10:5] & r2[19:14];
      1: bias = '1;
      2: bias = '0;
      default: bias = r2[10:5];
    endcase
    slot_done = bias;
    #1;
    for (int p = 0; p < NPIPE; p++) begin
      occ[p] = 0;
      run = 1'b1;
      for (int i = 0; i < NP; i++) begin
        if (mv[p][i]) occ[p]++;
        run = run & mv[p][i];
        pres[p][i] = run;
        chk("R8 slot valid", int'(slot_valid[p*NP+i]), int'(pres[p][i]));
        if (pres[p][i])
          chk("R2,R9 slot data", int'(slot_data[(p*NP+i)*W +: W]), int'(md[p][i]));
      end
    end
    erep = pipe_accept[0] && (occ[0] < NP);
    etag = pipe_accept[1] && (occ[1] < NP);
    ecoh = pipe_accept[2] && (occ[2] < NP);
    ereq = req_sysctl ? sc_ready : (req_uncached ? ub_ready : etag);
    etake = req_valid && !req_sysctl && !req_uncached && etag;
    chk("R1 rep_ready", int'(rep_ready), int'(erep));
    chk("R1 coh_ready", int'(coh_ready), int'(ecoh));
    chk("R3 req_ready", int'(req_ready), int'(ereq));
    chk("R3 sc_valid", int'(sc_valid), int'(req_valid && req_sysctl));
    chk("R3 ub_valid", int'(ub_valid), int'(req_valid && !req_sysctl && req_uncached));
    chk("R3 side data", int'(sc_data) + 256*int'(ub_data), int'(req_data) * 257);
    chk("R7 rel_strobe", int'(rel_strobe), int'(etake && !req_prefetch));
    chk("R4 in_empty", int'(in_empty), int'(mempty));
    chk("R5 inpipe_cnt", int'(inpipe_cnt), mcnt);
    chk("R6 req_full", int'(req_full), int'(mfull));
    // advance the model by one edge
    for (int p = 0; p < NPIPE; p++) begin
      logic         nv [NP];
      logic [W-1:0] nd [NP];
      int wp = 0;
      for (int i = 0; i < NP; i++) begin nv[i] = 1'b0; nd[i] = md[p][i]; end
      for (int i = 0; i < NP; i++) begin
        if (mv[p][i] && !(pres[p][i] && slot_done[p*NP+i])) begin
          nv[wp] = 1'b1; nd[wp] = md[p][i]; wp++;
        end else if (mv[p][i]) begin
          mcnt--;
        end
      end
      inval = (p == 0) ? rep_valid : (p == 1) ? (req_valid && !req_sysctl && !req_uncached) : coh_valid;
      rdy   = (p == 0) ? erep : (p == 1) ? etag : ecoh;
      if (inval && rdy) begin
        nv[wp] = 1'b1;
        nd[wp] = (p == 0) ? rep_data : (p == 1) ? req_data : coh_data;
        mcnt++;
      end
      for (int i = 0; i < NP; i++) begin mv[p][i] = nv[i]; md[p][i] = nd[i]; end
    end
    blocked = (rep_valid && !erep) || (req_valid && !ereq) || (coh_valid && !ecoh);
    mempty = !blocked;
    if (etake) mfull = 1'b0;
    else if (req_valid && (req_sysctl ? sc_ready : (req_uncached && ub_ready))) mfull = req_q_full;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rep_valid = 0; req_valid = 0; coh_valid = 0;
    rep_data = '0; req_data = '0; coh_data = '0;
    req_sysctl = 0; req_uncached = 0; req_prefetch = 0; req_q_full = 0;
    pipe_accept = '0; sc_ready = 0; ub_ready = 0; slot_done = '0;
    for (int p = 0; p < NPIPE; p++)
      for (int i = 0; i < NP; i++) begin mv[p][i] = 1'b0; md[p][i] = '0; end
    mcnt = 0; mempty = 1'b1; mfull = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset in_empty", int'(in_empty), 1);
    chk("R5 reset inpipe_cnt", int'(inpipe_cnt), 0);
    chk("R6 reset req_full", int'(req_full), 0);
    chk("R8 reset slot_valid", int'(slot_valid), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) one_cycle((c / 250) % 4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule